// File: doc/BRIEF.md
# Converter Channel Scan Sequencer

This block decides which analog input the converter samples next and marks every finished result with the channel it came from. It sits between the register bank and the converter core. A control register, written through a small address/data write port, picks one of two modes. In the fixed mode every conversion reuses one channel chosen in that register. In the sweep mode the block walks an ascending list of channel codes and wraps back to the start. The list holds the signal inputs and two calibration channels: one whose input is tied to ground for offset, and one tied to the reference for gain.

The signal inputs are arranged either as three differential pairs (codes 0 to 2) or as five single-ended inputs measured against a common node (codes 0 to 4). The offset and gain calibration channels take codes 6 and 7, and code 5 is never visited by the sweep. When the converter raises its done strobe, the block puts the next channel on its select output in that same cycle. One cycle later it presents the finished word with a 3-bit channel tag in its low bits.

Top module: `chan_scan_seq`

## Requirements
- R1: While reset is held low, and on the first cycle after it, `chan_sel` is 0 and `res_valid` is 0. The control register resets to fixed mode on channel 0 with the differential arrangement.
- R2: With control bit 0 (sweep) clear, every done strobe selects the channel code held in control bits 3:1.
- R3: With bit 0 set and bit 4 clear (differential arrangement), successive done strobes select 0, 1, 2, 6, 7 and then wrap to 0.
- R4: With bits 0 and 4 set (single-ended arrangement), successive done strobes select 0, 1, 2, 3, 4, 6, 7 and then wrap to 0.
- R5: `chan_sel` takes its new value in the same cycle `conv_done` is high, and otherwise holds the channel last selected.
- R6: One cycle after each done strobe, `res_valid` is high for exactly one cycle. `res_data` then holds the converted word in its upper bits and, in bits 2:0, the code of the channel that was being converted when the strobe came. `res_valid` is low in every cycle that does not follow a strobe.
- R7: A control write changes nothing until the next done strobe. A write made in the same cycle as a strobe first applies at the strobe after that.
- R8: Writes to any address other than 0 leave the selection unchanged. Bits 7:5 of the control word are ignored.
- R9: When sweep mode applies at a strobe, the next channel is the smallest listed code above the current channel, or the first code (0) if there is none. This holds even when the current channel came from fixed mode (for example 3 or 5 in the differential arrangement leads to 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register address; 0 is the control register |
| reg_wr_data | input | 8 | Write data: bit 0 sweep, bits 3:1 fixed channel, bit 4 single-ended arrangement |
| conv_done | input | 1 | Converter finished a conversion this cycle |
| conv_data | input | 16 | Converted word, valid with `conv_done` |
| chan_sel | output | 3 | Channel the converter is to sample |
| res_valid | output | 1 | Tagged result valid |
| res_data | output | 19 | Converted word (bits 18:3) and channel tag (bits 2:0) |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 3-bit tag, three differential or five single-ended inputs, and calibration codes 6 and 7. With these values the whole 8-code space is in play, including the unused code 5 and the gap it leaves in the sweep. This makes it possible to enter the sweep from channels that are off the list (3, 4 and 5 in the differential arrangement) and to cover wrap-around in both arrangements. The reference model steps through the list with back-to-back strobes as well as with idle gaps, and puts control writes both between strobes and in the cycle of a strobe.

// File: rtl/chan_scan_pkg.sv
// Package: shared types for the channel scan sequencer.
// Assumes a 3-bit channel code; the control layout below is the register layout.
package chan_scan_pkg;
    localparam int TAG_W = 3;

    typedef logic [TAG_W-1:0] chan_code_t;

    // Control word fields, most significant first: bit4 pseudo, bits3:1 fixed, bit0 scan
    typedef struct packed {
        logic       pseudo;
        chan_code_t fixed;
        logic       scan;
    } scan_cfg_t;

    localparam int CFG_W = $bits(scan_cfg_t);
endpackage

// File: rtl/scan_cfg_regs.sv
// Module: scan_cfg_regs
// Holds the control register written through the address/data port. Only
// CTRL_ADDR is implemented; other addresses and the upper data bits are dropped.
// Assumes REG_W >= CFG_W. The value is pending: the top applies it at a boundary.
module scan_cfg_regs
    import chan_scan_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int REG_W     = 8,
    parameter int CTRL_ADDR = 0,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output scan_cfg_t         cfg
);
    logic ctrl_hit;
    logic unused_hi_bits;

    assign ctrl_hit       = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign unused_hi_bits = ^wr_data[REG_W-1:CFG_W];

    // Capture a control write; reset to fixed mode, channel 0, differential
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (ctrl_hit)
            cfg <= scan_cfg_t'(wr_data[CFG_W-1:0]);
    end

    // R8: a write elsewhere in the bank leaves the control value untouched
    assert_other_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(CTRL_ADDR)) |=> $stable(cfg));
endmodule

// File: rtl/scan_next_chan.sv
// Module: scan_next_chan
// Works out the channel that follows the current one. In fixed mode it is the
// configured code; in sweep mode it is the next listed code above the current
// one, wrapping to the lowest listed code. Purely combinational.
// Assumes the calibration codes lie inside the code space.
module scan_next_chan
    import chan_scan_pkg::*;
#(
    parameter int DIFF_INPUTS   = 3,
    parameter int PSEUDO_INPUTS = 5,
    parameter int CAL_OFF_CODE  = 6,
    parameter int CAL_GAIN_CODE = 7,
    localparam int NUM_CODES    = 2 ** TAG_W
) (
    input  chan_code_t cur,
    input  scan_cfg_t  cfg,
    output chan_code_t nxt
);
    logic [NUM_CODES-1:0] member;
    int                   n_inputs;
    chan_code_t           first_code;
    chan_code_t           succ_code;
    logic                 succ_found;

    assign n_inputs = cfg.pseudo ? PSEUDO_INPUTS : DIFF_INPUTS;

    // One membership flag per code for the active arrangement
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_member
        assign member[c] = (c < n_inputs) || (c == CAL_OFF_CODE) || (c == CAL_GAIN_CODE);
    end

    // Scan codes from the top down so the lowest qualifying code wins
    always_comb begin
        first_code = '0;
        succ_code  = '0;
        succ_found = 1'b0;
        for (int c = NUM_CODES - 1; c >= 0; c--) begin
            if (member[c]) begin
                first_code = chan_code_t'(c);
                if (c > int'(cur)) begin
                    succ_code  = chan_code_t'(c);
                    succ_found = 1'b1;
                end
            end
        end
    end

    // Choose between the configured code and the list successor
    always_comb begin
        if (!cfg.scan)
            nxt = cfg.fixed;
        else if (succ_found)
            nxt = succ_code;
        else
            nxt = first_code;
    end
endmodule

// File: rtl/scan_result_tag.sv
// Module: scan_result_tag
// Registers each finished word with the channel tag in its low bits. The valid
// flag is a single-cycle pulse one cycle after the done strobe.
// Assumes the tag is the channel in use before the strobe's boundary.
module scan_result_tag
    import chan_scan_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int OUT_W = DATA_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  chan_code_t        tag,
    output logic              valid,
    output logic [OUT_W-1:0]  word
);
    // Pulse valid for one cycle after each strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= 1'b0;
        else
            valid <= done;
    end

    // Latch word and tag together on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (done)
            word <= {data, tag};
    end

    // R6: a strobe is always followed by a result, and a quiet cycle by none
    assert_result_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> valid);
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> !valid);
endmodule

// File: rtl/chan_scan_seq.sv
// Module: chan_scan_seq (top)
// Selects the converter channel and tags finished results. The current
// channel register moves only on a done strobe, and the control value in force
// is the pending register as it stood before that strobe's edge.
// Assumes conv_done is a single-cycle strobe per finished conversion.
module chan_scan_seq
    import chan_scan_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int NUM_REGS      = 8,
    parameter int REG_W         = 8,
    parameter int CTRL_ADDR     = 0,
    parameter int DIFF_INPUTS   = 3,
    parameter int PSEUDO_INPUTS = 5,
    parameter int CAL_OFF_CODE  = 6,
    parameter int CAL_GAIN_CODE = 7,
    localparam int ADDR_W       = $clog2(NUM_REGS),
    localparam int OUT_W        = DATA_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic [TAG_W-1:0]  chan_sel,
    output logic              res_valid,
    output logic [OUT_W-1:0]  res_data
);
    scan_cfg_t  cfg;
    chan_code_t cur_chan;
    chan_code_t nxt_chan;
    int         n_inputs;

    scan_cfg_regs #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (REG_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .cfg     (cfg)
    );

    scan_next_chan #(
        .DIFF_INPUTS   (DIFF_INPUTS),
        .PSEUDO_INPUTS (PSEUDO_INPUTS),
        .CAL_OFF_CODE  (CAL_OFF_CODE),
        .CAL_GAIN_CODE (CAL_GAIN_CODE)
    ) u_next (
        .cur (cur_chan),
        .cfg (cfg),
        .nxt (nxt_chan)
    );

    scan_result_tag #(
        .DATA_W (DATA_W)
    ) u_tag (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (conv_done),
        .data  (conv_data),
        .tag   (cur_chan),
        .valid (res_valid),
        .word  (res_data)
    );

    // Advance the channel in use at each conversion boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_chan <= '0;
        else if (conv_done)
            cur_chan <= nxt_chan;
    end

    // Show the coming channel in the strobe cycle itself
    assign chan_sel = conv_done ? nxt_chan : cur_chan;

    assign n_inputs = cfg.pseudo ? PSEUDO_INPUTS : DIFF_INPUTS;

    // R1: reset leaves channel 0 selected and no result pending
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cur_chan == '0 && !res_valid));

    // R2: fixed mode selects the configured code at each boundary
    assert_fixed_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !cfg.scan) |-> chan_sel == cfg.fixed);

    // R3: in sweep mode only listed codes are ever selected
    assert_scan_member_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cfg.scan) |-> (int'(chan_sel) < n_inputs
            || int'(chan_sel) == CAL_OFF_CODE || int'(chan_sel) == CAL_GAIN_CODE));

    // R9: sweep moves upward or wraps to the first code
    assert_scan_upward_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cfg.scan) |-> (chan_sel > cur_chan || chan_sel == '0));

    // R5: the strobe-cycle selection is the channel held afterwards
    assert_sel_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> cur_chan == $past(chan_sel));

    // R6: the result tag names the channel that was converted
    assert_tag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> res_data[TAG_W-1:0] == $past(cur_chan));
endmodule

// File: tb/chan_scan_seq_tb.sv
module chan_scan_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [7:0]  reg_wr_data = '0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic [2:0]  chan_sel;
    logic        res_valid;
    logic [18:0] res_data;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    int          m_cur = 0;
    int          m_scan = 0;
    int          m_fixed = 0;
    int          m_pseudo = 0;
    logic        m_valid = 1'b0;
    logic [18:0] m_word = '0;

    chan_scan_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .conv_done   (conv_done),
        .conv_data   (conv_data),
        .chan_sel    (chan_sel),
        .res_valid   (res_valid),
        .res_data    (res_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Successor in the ascending sweep list for the current arrangement
    function automatic int list_succ(input int cur);
        int lst[$];
        int n = (m_pseudo != 0) ? 5 : 3;
        for (int i = 0; i < n; i++) lst.push_back(i);
        lst.push_back(6);
        lst.push_back(7);
        foreach (lst[i]) if (lst[i] > cur) return lst[i];
        return lst[0];
    endfunction

    function automatic int next_of(input int cur);
        return (m_scan != 0) ? list_succ(cur) : m_fixed;
    endfunction

    // One clock: drive at negedge, check selection, model the edge, check result
    task automatic step(input bit done, input logic [15:0] data, input bit wr,
                        input logic [2:0] addr, input logic [7:0] wd, input string req);
        int exp_sel;
        conv_done   = done;
        conv_data   = data;
        reg_wr_en   = wr;
        reg_wr_addr = addr;
        reg_wr_data = wd;
        #1;
        exp_sel = done ? next_of(m_cur) : m_cur;
        chk(int'(chan_sel) == exp_sel, req, int'(chan_sel), exp_sel);
        @(posedge clk);
        m_valid = done;
        if (done) begin
            m_word = {data, 3'(m_cur)};
            m_cur  = exp_sel;
        end
        if (wr && addr == 3'd0) begin
            m_scan   = int'(wd[0]);
            m_fixed  = int'(wd[3:1]);
            m_pseudo = int'(wd[4]);
        end
        @(negedge clk);
        chk(res_valid == m_valid, "R6", int'(res_valid), int'(m_valid));
        if (m_valid)
            chk(res_data == m_word, "R6", int'(res_data), int'(m_word));
    endtask

    task automatic conv(input logic [15:0] data, input string req);
        step(1'b1, data, 1'b0, 3'd0, 8'h00, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 16'h0, 1'b0, 3'd0, 8'h00, req);
    endtask

    task automatic wr_reg(input logic [2:0] addr, input logic [7:0] wd, input string req);
        step(1'b0, 16'h0, 1'b1, addr, wd, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(chan_sel == 3'd0, "R1", int'(chan_sel), 0);
        chk(res_valid == 1'b0, "R1", int'(res_valid), 0);
        rst_n = 1'b1;
        #1;
        chk(chan_sel == 3'd0, "R1", int'(chan_sel), 0);
        @(negedge clk);
        chk(res_valid == 1'b0, "R1", int'(res_valid), 0);

        // R2: fixed channel 0, with gaps and back to back
        conv(16'hA001, "R2");
        idle("R5");
        conv(16'hA002, "R2");
        conv(16'hA003, "R2");

        // R7: write fixed 5 between strobes; no effect until the boundary
        wr_reg(3'd0, 8'h0A, "R7");
        idle("R7");
        conv(16'hB001, "R5");
        idle("R5");
        conv(16'hB002, "R2");

        // R8: other address and upper bits ignored
        wr_reg(3'd3, 8'h11, "R8");
        conv(16'hB003, "R8");
        wr_reg(3'd0, 8'hEA, "R8");
        conv(16'hB004, "R8");

        // R7: write sweep with a strobe in the same cycle; old mode applies first
        step(1'b1, 16'hC000, 1'b1, 3'd0, 8'h01, "R7");
        // R9: from 5 the sweep goes to 6
        conv(16'hC001, "R9");
        // R3: differential list wraps
        for (int i = 0; i < 7; i++) conv(16'hC100 + 16'(i), "R3");
        idle("R5");

        // R4: single-ended arrangement
        wr_reg(3'd0, 8'h11, "R7");
        for (int i = 0; i < 9; i++) begin
            conv(16'hD000 + 16'(i), "R4");
            if (i % 3 == 0) idle("R5");
        end

        // R9: fixed 3 then sweep in differential arrangement goes to 6
        wr_reg(3'd0, 8'h06, "R2");
        conv(16'hE000, "R2");
        wr_reg(3'd0, 8'h01, "R9");
        conv(16'hE001, "R9");
        conv(16'hE002, "R3");
        conv(16'hE003, "R3");

        // R9: fixed 4 then single-ended sweep goes to 6; 5 leads to 6 too
        wr_reg(3'd0, 8'h08, "R2");
        conv(16'hE100, "R2");
        wr_reg(3'd0, 8'h11, "R9");
        conv(16'hE101, "R9");
        wr_reg(3'd0, 8'h0A, "R2");
        conv(16'hE102, "R2");
        wr_reg(3'd0, 8'h11, "R9");
        conv(16'hE103, "R9");
        conv(16'hE104, "R4");
        idle("R6");
        idle("R6");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule